// File: doc/BRIEF.md
# Magnetic Memory Word Write Controller with Verify and Masked Retry

This block carries out a single-word write into a non-volatile magnetic memory array. A client presents an address and a 79-bit stored word (64 data bits, 14 check bits and 1 spare-column bit, all handled alike as bits 0 to 78). The controller first reads the current contents. It then drives a timed write pulse that touches only the bits that must change. Finally it reads the word back to confirm it.

Any bit still wrong after the read-back is rewritten on its own, through a per-bit write mask. This repeats until the word matches or a retry budget is spent. A busy output covers the whole operation. When busy drops, a one-cycle done pulse reports the end of the operation, together with the number of rewrites used and a sticky failure flag.

The array side is a plain port: a read enable, a write enable with data and a per-bit mask, and read data that the array returns combinationally during a read phase.

Top module: `mram_wv_ctrl`

## Requirements
- R1: A request is taken only while busy is low. Address and word are captured at that edge, and busy is high from the next cycle on.
- R2: Each operation runs in a fixed order: a read phase of PRE_CYC cycles with the read enable high, then a write pulse of PULSE_CYC cycles with the write enable high, then a read-back phase of VFY_CYC cycles with the read enable high. A clean write keeps busy high for PRE_CYC+PULSE_CYC+VFY_CYC cycles (20 with the defaults).
- R3: The mask of the first write pulse has a 1 at exactly the bit positions where the pre-read word differs from the requested word.
- R4: If the pre-read word already equals the requested word, no write pulse is issued, and busy lasts PRE_CYC+VFY_CYC cycles.
- R5: After a read-back with mismatches, the next write pulse uses a mask holding only the mismatching bits and is followed by another read-back phase.
- R6: At most MAX_RETRY (8) rewrites follow the first pulse. The retry count output gives the number used, 0 to 8, and holds it until the next accepted request.
- R7: If mismatches remain after the last allowed rewrite, the fail flag rises together with done, stays high, and is cleared when the next request is accepted.
- R8: done is high for exactly one cycle, the first cycle in which busy is low after an operation.
- R9: A request arriving while busy is high has no effect: nothing is written at its address, and the running operation completes with its own captured word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request strobe |
| reqAddr | input | ADDR_W | Word address of the request |
| reqData | input | WORD_W | Word to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| writeFail | output | 1 | Sticky: word not confirmed within the retry budget |
| retryCount | output | RETRY_W | Rewrites used by the last operation |
| arrAddr | output | ADDR_W | Array word address |
| arrRdEn | output | 1 | Array read enable |
| arrRdData | input | WORD_W | Array read data |
| arrWrEn | output | 1 | Array write pulse |
| arrWrData | output | WORD_W | Array write data |
| arrWrMask | output | WORD_W | Per-bit write enable |

## Verification
The bench builds the block with its default parameters: phases of 3, 14 and 3 cycles and a budget of 8 rewrites. With these values each busy length has a closed form of 3 + 17·pulses (6 when the pulse is skipped), and the exhausted-budget case of nine failing pulses ends after 156 cycles, well inside the run. The array model makes chosen bits of a chosen address refuse a given number of pulses. This brings the masked rewrites, the exact retry limit and the sticky failure flag within reach, and the model records every pulse mask for comparison.

// File: rtl/mram_wv_pkg.sv
package mram_wv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_PULSE,
    ST_VFY
  } wvPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request address and word
    logic capMask;  // capture read-versus-target difference as next mask
    logic rdEn;     // array read phase
    logic wrEn;     // array write pulse
  } wvStrobe_t;

endpackage

// File: rtl/mram_wv_dp.sv
module mram_wv_dp
  import mram_wv_pkg::*;
#(
  parameter int WORD_W = 79,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  wvStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  input  logic [WORD_W-1:0] arrRdData,
  output logic              diffZero,
  output logic [ADDR_W-1:0] arrAddr,
  output logic              arrRdEn,
  output logic              arrWrEn,
  output logic [WORD_W-1:0] arrWrData,
  output logic [WORD_W-1:0] arrWrMask
);

  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] dataReg;
  logic [WORD_W-1:0] maskReg;
  logic [WORD_W-1:0] diffNow;

  assign diffNow  = arrRdData ^ dataReg;
  assign diffZero = ~|diffNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      maskReg <= '0;
    end else begin
      if (strb.load) begin
        addrReg <= reqAddr;
        dataReg <= reqData;
      end
      if (strb.capMask) maskReg <= diffNow;
    end
  end

  assign arrAddr   = addrReg;
  assign arrRdEn   = strb.rdEn;
  assign arrWrEn   = strb.wrEn;
  assign arrWrData = dataReg;
  assign arrWrMask = strb.wrEn ? maskReg : '0;

  // R4/R5: a pulse is never issued with nothing to write
  a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (arrWrMask != '0));

  // R1: target word and address are frozen while the pulse is on
  a_r1_pulse_stable: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |-> ($stable(arrWrData) && $stable(arrAddr)));

endmodule

// File: rtl/mram_wv_ctl.sv
module mram_wv_ctl
  import mram_wv_pkg::*;
#(
  parameter int PRE_CYC   = 3,
  parameter int PULSE_CYC = 14,
  parameter int VFY_CYC   = 3,
  parameter int MAX_RETRY = 8,
  parameter int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               diffZero,
  output wvStrobe_t          strb,
  output logic               busy,
  output logic               done,
  output logic               writeFail,
  output logic [RETRY_W-1:0] retryCount
);

  localparam int MAX_CYC = (PULSE_CYC > PRE_CYC)
                         ? ((PULSE_CYC > VFY_CYC) ? PULSE_CYC : VFY_CYC)
                         : ((PRE_CYC > VFY_CYC) ? PRE_CYC : VFY_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0]   PRE_LAST   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0]   PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0]   VFY_LAST   = CNT_W'(VFY_CYC - 1);
  localparam logic [RETRY_W-1:0] RETRY_MAX  = RETRY_W'(MAX_RETRY);

  wvPhase_e         phase;
  logic [CNT_W-1:0] phaseCnt;
  logic             phaseEnd;

  assign phaseEnd = (phaseCnt == '0);
  assign busy     = (phase != ST_IDLE);

  always_comb begin
    strb.load    = (phase == ST_IDLE) && reqValid;
    strb.capMask = ((phase == ST_PRE) || (phase == ST_VFY)) && phaseEnd;
    strb.rdEn    = (phase == ST_PRE) || (phase == ST_VFY);
    strb.wrEn    = (phase == ST_PULSE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= ST_IDLE;
      phaseCnt   <= '0;
      done       <= 1'b0;
      writeFail  <= 1'b0;
      retryCount <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        ST_IDLE: begin
          if (reqValid) begin
            phase      <= ST_PRE;
            phaseCnt   <= PRE_LAST;
            retryCount <= '0;
            writeFail  <= 1'b0;
          end
        end
        ST_PRE: begin
          if (!phaseEnd) begin
            phaseCnt <= phaseCnt - 1'b1;
          end else if (diffZero) begin
            phase    <= ST_VFY;
            phaseCnt <= VFY_LAST;
          end else begin
            phase    <= ST_PULSE;
            phaseCnt <= PULSE_LAST;
          end
        end
        ST_PULSE: begin
          if (!phaseEnd) begin
            phaseCnt <= phaseCnt - 1'b1;
          end else begin
            phase    <= ST_VFY;
            phaseCnt <= VFY_LAST;
          end
        end
        ST_VFY: begin
          if (!phaseEnd) begin
            phaseCnt <= phaseCnt - 1'b1;
          end else if (diffZero) begin
            phase <= ST_IDLE;
            done  <= 1'b1;
          end else if (retryCount == RETRY_MAX) begin
            phase     <= ST_IDLE;
            done      <= 1'b1;
            writeFail <= 1'b1;
          end else begin
            phase      <= ST_PULSE;
            phaseCnt   <= PULSE_LAST;
            retryCount <= retryCount + 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R8: done marks the cycle in which busy has just fallen
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R6: retry count never exceeds the budget
  a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rstN)
    retryCount <= RETRY_MAX);

  // R7: failure is raised only at completion
  a_r7_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeFail) |-> done);

  // R2: a write pulse is followed only by more pulse or a read-back
  a_r2_pulse_then_verify: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_PULSE) |=> (phase == ST_PULSE || phase == ST_VFY));

  // R9: nothing is captured while an operation runs
  a_r9_no_load_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.load);

endmodule

// File: rtl/mram_wv_ctrl.sv
module mram_wv_ctrl
  import mram_wv_pkg::*;
#(
  parameter int WORD_W    = 79,
  parameter int ADDR_W    = 12,
  parameter int PRE_CYC   = 3,
  parameter int PULSE_CYC = 14,
  parameter int VFY_CYC   = 3,
  parameter int MAX_RETRY = 8,
  parameter int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]  reqData,
  output logic               busy,
  output logic               done,
  output logic               writeFail,
  output logic [RETRY_W-1:0] retryCount,
  output logic [ADDR_W-1:0]  arrAddr,
  output logic               arrRdEn,
  input  logic [WORD_W-1:0]  arrRdData,
  output logic               arrWrEn,
  output logic [WORD_W-1:0]  arrWrData,
  output logic [WORD_W-1:0]  arrWrMask
);

  wvStrobe_t strb;
  logic      diffZero;

  mram_wv_ctl #(
    .PRE_CYC  (PRE_CYC),
    .PULSE_CYC(PULSE_CYC),
    .VFY_CYC  (VFY_CYC),
    .MAX_RETRY(MAX_RETRY),
    .RETRY_W  (RETRY_W)
  ) i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .diffZero  (diffZero),
    .strb      (strb),
    .busy      (busy),
    .done      (done),
    .writeFail (writeFail),
    .retryCount(retryCount)
  );

  mram_wv_dp #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .arrRdData(arrRdData),
    .diffZero (diffZero),
    .arrAddr  (arrAddr),
    .arrRdEn  (arrRdEn),
    .arrWrEn  (arrWrEn),
    .arrWrData(arrWrData),
    .arrWrMask(arrWrMask)
  );

endmodule

// File: tb/test_mram_wv_ctrl.sv
module test_mram_wv_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 79;
  localparam int ADDR_W = 12;
  localparam int RETRY_W = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic [WORD_W-1:0]  reqData = '0;
  logic               busy, done, writeFail;
  logic [RETRY_W-1:0] retryCount;
  logic [ADDR_W-1:0]  arrAddr;
  logic               arrRdEn, arrWrEn;
  logic [WORD_W-1:0]  arrRdData, arrWrData, arrWrMask;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mram_wv_ctrl i_mram_wv_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .busy(busy), .done(done), .writeFail(writeFail),
    .retryCount(retryCount), .arrAddr(arrAddr), .arrRdEn(arrRdEn),
    .arrRdData(arrRdData), .arrWrEn(arrWrEn), .arrWrData(arrWrData),
    .arrWrMask(arrWrMask)
  );

  // ---------------- array model ----------------
  logic [WORD_W-1:0] mem [16];
  int                failCnt [WORD_W];
  logic [3:0]        failAddr = '0;
  logic              wrPrev = 1'b0;
  int                pulseNum = 0;
  int                rdCyc = 0;
  int                wrCyc = 0;
  logic [WORD_W-1:0] pulseMask [16];

  assign arrRdData = arrRdEn ? mem[arrAddr[3:0]] : '0;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    for (int b = 0; b < WORD_W; b++) failCnt[b] = 0;
  end

  always @(posedge clk) begin
    logic [WORD_W-1:0] okMask;
    wrPrev <= arrWrEn;
    if (arrRdEn) rdCyc <= rdCyc + 1;
    if (arrWrEn) wrCyc <= wrCyc + 1;
    if (arrWrEn && !wrPrev) begin
      okMask = arrWrMask;
      if (arrAddr[3:0] == failAddr) begin
        for (int b = 0; b < WORD_W; b++) begin
          if (arrWrMask[b] && failCnt[b] > 0) begin
            okMask[b] = 1'b0;
            failCnt[b] = failCnt[b] - 1;
          end
        end
      end
      mem[arrAddr[3:0]] <= (mem[arrAddr[3:0]] & ~okMask) | (arrWrData & okMask);
      if (pulseNum < 16) pulseMask[pulseNum] <= arrWrMask;
      pulseNum <= pulseNum + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // issue one request, wait for completion, check timing and outcome
  task automatic runOp(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                       input int expPulses, input int expRetry, input bit expFail,
                       input bit intrude);
    int n = 0;
    int expBusy;
    @(negedge clk);
    pulseNum = 0; rdCyc = 0; wrCyc = 0;
    reqValid = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqData = ~d;   // R1: inputs change after capture
    chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
    while (busy && n < 1000) begin
      n++;
      if (intrude && n == 5) begin
        reqValid = 1'b1; reqAddr = 12'h00F; reqData = {WORD_W{1'b1}};  // R9
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    expBusy = (expPulses == 0) ? 6 : 3 + 17 * expPulses;
    chk(n == expBusy, expPulses == 0 ? "R4" : "R2", "busy cycles", n, expBusy);
    chk(done == 1'b1, "R8", "done at busy fall", done, 1);
    chk(pulseNum == expPulses, "R5", "pulse count", pulseNum, expPulses);
    chk(wrCyc == 14 * expPulses, "R2", "write cycles", wrCyc, 14 * expPulses);
    chk(rdCyc == 3 + 3 * ((expPulses == 0) ? 1 : expPulses), "R2", "read cycles",
        rdCyc, 3 + 3 * ((expPulses == 0) ? 1 : expPulses));
    chk(retryCount == expRetry, "R6", "retry count", retryCount, expRetry);
    chk(writeFail == expFail, "R7", "fail flag", writeFail, expFail);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    chk(writeFail == expFail, "R7", "fail flag held", writeFail, expFail);
  endtask

  // ---------------- scenarios ----------------
  task automatic tResetState();
    chk(busy == 0 && done == 0 && writeFail == 0 && retryCount == 0,
        "R1", "reset outputs", {busy, done, writeFail}, 0);
    chk(arrRdEn == 0 && arrWrEn == 0, "R2", "array idle at reset", {arrRdEn, arrWrEn}, 0);
  endtask

  task automatic tCleanWrite();
    logic [WORD_W-1:0] d = {15'h5A5A, 64'h0123_4567_89AB_CDEF};
    runOp(12'h001, d, 1, 0, 0, 0);
    chk(mem[1] == d, "R1", "stored word uses captured data", mem[1], d);
    chk(pulseMask[0] == d, "R3", "first mask equals diff", pulseMask[0], d);
  endtask

  task automatic tPartialChange();
    logic [WORD_W-1:0] d = mem[1] ^ {1'b1, 14'h0, 64'h0000_0000_0000_0101};
    runOp(12'h001, d, 1, 0, 0, 0);
    chk(pulseMask[0] == (d ^ {15'h5A5A, 64'h0123_4567_89AB_CDEF}), "R3",
        "mask only changed bits", pulseMask[0], d ^ {15'h5A5A, 64'h0123_4567_89AB_CDEF});
    chk(mem[1] == d, "R3", "word after partial change", mem[1], d);
  endtask

  task automatic tSameData();
    logic [WORD_W-1:0] d = mem[1];
    runOp(12'h001, d, 0, 0, 0, 0);
    chk(mem[1] == d, "R4", "word unchanged", mem[1], d);
  endtask

  task automatic tMaskedRetry();
    logic [WORD_W-1:0] d = {WORD_W{1'b1}};
    logic [WORD_W-1:0] bad = '0;
    bad[5] = 1'b1; bad[70] = 1'b1; bad[78] = 1'b1;
    failAddr = 4'h2;
    failCnt[5] = 2; failCnt[70] = 2; failCnt[78] = 2;
    runOp(12'h002, d, 3, 2, 0, 0);
    chk(pulseMask[0] == d, "R3", "first mask all bits", pulseMask[0], d);
    chk(pulseMask[1] == bad, "R5", "second mask failing bits only", pulseMask[1], bad);
    chk(pulseMask[2] == bad, "R5", "third mask failing bits only", pulseMask[2], bad);
    chk(mem[2] == d, "R5", "word after retries", mem[2], d);
  endtask

  task automatic tExhaust();
    logic [WORD_W-1:0] d = '0;
    logic [WORD_W-1:0] exp;
    d[40] = 1'b1; d[0] = 1'b1;
    exp = '0; exp[0] = 1'b1;
    failAddr = 4'h3;
    failCnt[40] = 9;
    runOp(12'h003, d, 9, 8, 1, 0);
    chk(mem[3] == exp, "R6", "bit stays wrong after budget", mem[3], exp);
    chk(pulseMask[8][40] == 1'b1 && pulseMask[8][0] == 1'b0, "R5",
        "last mask only bit 40", pulseMask[8], exp << 40);
  endtask

  task automatic tFailClears();
    logic [WORD_W-1:0] d = 79'h3;
    chk(writeFail == 1'b1, "R7", "fail still held while idle", writeFail, 1);
    runOp(12'h004, d, 1, 0, 0, 0);
  endtask

  task automatic tIgnoreBusyReq();
    logic [WORD_W-1:0] d = 79'h1234;
    runOp(12'h005, d, 1, 0, 0, 1);
    chk(mem[15] == '0, "R9", "intruding address untouched", mem[15], 0);
    chk(mem[5] == d, "R9", "running write keeps own word", mem[5], d);
    chk(busy == 1'b0, "R9", "no second operation started", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tCleanWrite();
    tPartialChange();
    tSameData();
    tMaskedRetry();
    tExhaust();
    tFailClears();
    tIgnoreBusyReq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule